// File: doc/BRIEF.md
# Chained Serializer Readout and Fault Checker

This block is the host-side engine that reads a daisy chain of `N_DEV` eight-input serializer devices in a single SPI transfer. A one-cycle start pulse opens the transfer. Chip select is held low while the block clocks in one byte per device in fast mode, or two bytes per device (input byte, then status byte) in status mode. When the transfer closes, the stream is split per device. Each status byte is checked against a 5-bit CRC of its input byte and against its alarm bits. The result is combined with the fault pin inputs, and a per-device valid mask, the per-device error bitmaps and the `N_DEV*8`-bit input vector are published together with a one-cycle done pulse.

A faulting device does not spoil the chain: its input byte reads as zero and its valid bit is clear, while the other devices deliver their data. Global input k is bit k%8 of device k/8, so it sits at bit k of `data_o`. The fault pins are either one pin per device or one pin shared by the whole chain, chosen by a parameter. The SCLK divider and the chain length are elaboration-time parameters.

Top module: `chain_reader`

## Requirements
- R1: A start pulse while idle drops `spi_cs_no` low and sets `busy_o`. SCLK idles low and each half period lasts `CLK_DIV` clocks. MISO is sampled on each rising SCLK edge, MSB first. There are exactly `N_DEV*16` rising edges in status mode (`status_mode_i`=1) and `N_DEV*8` in fast mode. Then chip select returns high and SCLK stays low while chip select is high.
- R2: Stream bytes are numbered from 0 in arrival order. In status mode, device d's input byte is byte 2d and its status byte is byte 2d+1. In fast mode, device d's input byte is byte d. A valid device's input byte appears at `data_o[8d+7:8d]`.
- R3: In status mode, `crc_err_o[d]` is set when status bits [7:3] differ from the CRC of the input byte. The CRC uses polynomial x^5+x^4+x^2+1, a zero initial value and MSB-first processing. A CRC error marks the device faulting.
- R4: In status mode, status bit 1 = 1 sets `ovt_o[d]` and marks the device faulting.
- R5: In status mode, status bit 2 = 0 sets `uv_alarm_o[d]` and marks the device faulting. Status bit 0 = 0 sets `uv_warn_o[d]`, which alone leaves the device valid.
- R6: With ignore-undervoltage set, `uv_alarm_o`, `uv_warn_o` and `fault_o` read 0, and neither undervoltage bits nor fault pins mark any device faulting.
- R7: A high fault pin sets `fault_o[d]` and marks the device faulting. With `SHARED_FAULT`=1 the single pin applies to every device; otherwise pin d applies to device d. Pins are sampled at the end of the transfer.
- R8: In fast mode, `crc_err_o`, `ovt_o`, `uv_alarm_o` and `uv_warn_o` read 0, and only the fault pin can mark a device faulting.
- R9: `valid_o[d]` is 1 exactly when device d is not faulting. A faulting device's data byte reads 0, while the other devices' bytes are still delivered.
- R10: All result outputs change only in the cycle `done_o` is high. That is one cycle after chip select rises, and `done_o` lasts one cycle. After reset all result outputs are 0.
- R11: A start pulse while `busy_o` is high is ignored; the running transfer is neither restarted nor lengthened.
- R12: The mode and ignore-undervoltage settings are captured at the accepted start. Changes during a transfer do not affect its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for one chain readout |
| status_mode_i | input | 1 | 1: two bytes per device with status; 0: input byte only |
| ignore_uv_i | input | 1 | Suppress undervoltage bits and fault pins |
| fault_i | input | SHARED_FAULT ? 1 : N_DEV | Fault pin(s), active high |
| spi_sclk_o | output | 1 | SPI clock, idle low |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_miso_i | input | 1 | Serial data from the chain |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse: results updated |
| data_o | output | N_DEV*8 | Input vector, bit k = global input k |
| valid_o | output | N_DEV | Per-device data valid |
| crc_err_o | output | N_DEV | Per-device CRC mismatch |
| ovt_o | output | N_DEV | Per-device overtemperature |
| uv_alarm_o | output | N_DEV | Per-device undervoltage alarm |
| uv_warn_o | output | N_DEV | Per-device undervoltage warning |
| fault_o | output | N_DEV | Per-device fault pin seen |

## Verification
The bench targets the status-byte offset. A design that swapped the input and status bytes, or counted bytes from the wrong end, would report CRC errors on clean streams. It checks that a lone undervoltage warning keeps data valid; a design treating it as an alarm would blank that device. It checks that the ignore setting also masks the fault pins and is held from the accepted start even when the input flips mid-transfer. It checks that a shared pin blanks every device while per-device pins blank one. A start pulse in mid-transfer is also applied; a design that restarted would show extra SCLK edges.

// File: rtl/chain_pkg.sv
package chain_pkg;
  localparam logic [4:0] CRC5_POLY = 5'h15;

  function automatic logic [4:0] crc5_msb(input logic [7:0] d);
    logic [4:0] c;
    logic       fb;
    c = '0;
    for (int b = 7; b >= 0; b--) begin
      fb = c[4] ^ d[b];
      c  = {c[3:0], 1'b0} ^ (fb ? CRC5_POLY : 5'h00);
    end
    return c;
  endfunction
endpackage

// File: rtl/chain_spi_rx.sv
module chain_spi_rx #(
  parameter int unsigned N_DEV   = 3,
  parameter int unsigned CLK_DIV = 2,
  localparam int unsigned FW = N_DEV * 16,
  localparam int unsigned CW = $clog2(FW + 1),
  localparam int unsigned DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          status_mode_i,
  input  logic          miso_i,
  output logic          sclk_o,
  output logic          cs_no,
  output logic          busy_o,
  output logic [FW-1:0] frame_o,
  output logic          frame_valid_o
);
  logic          xfer_q;
  logic [DW-1:0] div_q;
  logic [CW-1:0] left_q;
  logic          tick;

  assign tick   = (div_q == DW'(CLK_DIV - 1));
  assign busy_o = xfer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xfer_q        <= 1'b0;
      div_q         <= '0;
      left_q        <= '0;
      sclk_o        <= 1'b0;
      cs_no         <= 1'b1;
      frame_o       <= '0;
      frame_valid_o <= 1'b0;
    end else begin
      frame_valid_o <= 1'b0;
      if (!xfer_q) begin
        if (start_i) begin
          xfer_q <= 1'b1;
          cs_no  <= 1'b0;
          sclk_o <= 1'b0;
          div_q  <= '0;
          left_q <= status_mode_i ? CW'(FW) : CW'(FW / 2);
        end
      end else begin
        div_q <= tick ? '0 : div_q + 1'b1;
        if (tick) begin
          if (!sclk_o) begin
            sclk_o  <= 1'b1;
            frame_o <= {frame_o[FW-2:0], miso_i};
            left_q  <= left_q - 1'b1;
          end else begin
            sclk_o <= 1'b0;
            if (left_q == '0) begin
              xfer_q        <= 1'b0;
              cs_no         <= 1'b1;
              frame_valid_o <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/chain_dev_check.sv
module chain_dev_check
  import chain_pkg::*;
(
  input  logic [7:0] in_byte_i,
  input  logic [7:0] st_byte_i,
  input  logic       status_mode_i,
  input  logic       ignore_uv_i,
  input  logic       fault_pin_i,
  output logic       crc_err_o,
  output logic       ovt_o,
  output logic       uv_alarm_o,
  output logic       uv_warn_o,
  output logic       fault_o,
  output logic       bad_o
);
  logic [4:0] crc;

  always_comb begin
    crc        = crc5_msb(in_byte_i);
    crc_err_o  = status_mode_i && (st_byte_i[7:3] != crc);
    ovt_o      = status_mode_i && st_byte_i[1];
    uv_alarm_o = status_mode_i && !ignore_uv_i && !st_byte_i[2];
    uv_warn_o  = status_mode_i && !ignore_uv_i && !st_byte_i[0];
    fault_o    = !ignore_uv_i && fault_pin_i;
    // warning alone does not block data
    bad_o      = crc_err_o | ovt_o | uv_alarm_o | fault_o;
  end
endmodule

// File: rtl/chain_reader.sv
module chain_reader #(
  parameter int unsigned N_DEV        = 3,
  parameter int unsigned CLK_DIV      = 2,
  parameter bit          SHARED_FAULT = 1'b0,
  localparam int unsigned FPW = SHARED_FAULT ? 1 : N_DEV,
  localparam int unsigned FW  = N_DEV * 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               status_mode_i,
  input  logic               ignore_uv_i,
  input  logic [FPW-1:0]     fault_i,
  output logic               spi_sclk_o,
  output logic               spi_cs_no,
  input  logic               spi_miso_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [N_DEV*8-1:0] data_o,
  output logic [N_DEV-1:0]   valid_o,
  output logic [N_DEV-1:0]   crc_err_o,
  output logic [N_DEV-1:0]   ovt_o,
  output logic [N_DEV-1:0]   uv_alarm_o,
  output logic [N_DEV-1:0]   uv_warn_o,
  output logic [N_DEV-1:0]   fault_o
);
  logic          mode_q, ign_q;
  logic [FW-1:0] frame;
  logic          frame_valid;

  logic [N_DEV*8-1:0] dat_w;
  logic [N_DEV-1:0]   crc_w, ovt_w, uva_w, uvw_w, flt_w, bad_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      ign_q  <= 1'b0;
    end else if (start_i && !busy_o) begin
      mode_q <= status_mode_i;
      ign_q  <= ignore_uv_i;
    end
  end

  chain_spi_rx #(.N_DEV(N_DEV), .CLK_DIV(CLK_DIV)) u_rx (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .status_mode_i (status_mode_i),
    .miso_i        (spi_miso_i),
    .sclk_o        (spi_sclk_o),
    .cs_no         (spi_cs_no),
    .busy_o        (busy_o),
    .frame_o       (frame),
    .frame_valid_o (frame_valid)
  );

  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    // first byte received ends up at the top of the frame
    localparam int unsigned IN_S = (2 * N_DEV - 1 - 2 * d) * 8;
    localparam int unsigned ST_S = (2 * N_DEV - 2 - 2 * d) * 8;
    localparam int unsigned IN_F = (N_DEV - 1 - d) * 8;
    localparam int unsigned FP   = SHARED_FAULT ? 0 : d;

    logic [7:0] in_b;
    assign in_b = mode_q ? frame[IN_S +: 8] : frame[IN_F +: 8];

    chain_dev_check u_chk (
      .in_byte_i     (in_b),
      .st_byte_i     (frame[ST_S +: 8]),
      .status_mode_i (mode_q),
      .ignore_uv_i   (ign_q),
      .fault_pin_i   (fault_i[FP]),
      .crc_err_o     (crc_w[d]),
      .ovt_o         (ovt_w[d]),
      .uv_alarm_o    (uva_w[d]),
      .uv_warn_o     (uvw_w[d]),
      .fault_o       (flt_w[d]),
      .bad_o         (bad_w[d])
    );

    assign dat_w[d*8 +: 8] = bad_w[d] ? 8'h00 : in_b;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      data_o     <= '0;
      valid_o    <= '0;
      crc_err_o  <= '0;
      ovt_o      <= '0;
      uv_alarm_o <= '0;
      uv_warn_o  <= '0;
      fault_o    <= '0;
    end else begin
      done_o <= frame_valid;
      if (frame_valid) begin
        data_o     <= dat_w;
        valid_o    <= ~bad_w;
        crc_err_o  <= crc_w;
        ovt_o      <= ovt_w;
        uv_alarm_o <= uva_w;
        uv_warn_o  <= uvw_w;
        fault_o    <= flt_w;
      end
    end
  end
endmodule

// File: rtl/chain_reader_chk.sv
module chain_reader_chk #(
  parameter int unsigned N_DEV = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               busy_o,
  input logic               spi_cs_no,
  input logic               spi_sclk_o,
  input logic               done_o,
  input logic [N_DEV*8-1:0] data_o,
  input logic [N_DEV-1:0]   valid_o,
  input logic [N_DEV-1:0]   crc_err_o,
  input logic [N_DEV-1:0]   ovt_o,
  input logic [N_DEV-1:0]   uv_alarm_o,
  input logic [N_DEV-1:0]   uv_warn_o,
  input logic [N_DEV-1:0]   fault_o
);
  assert_cs_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> spi_cs_no);

  assert_sclk_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sclk_o);

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(valid_o) && $stable(data_o) && $stable(crc_err_o)
                 && $stable(ovt_o) && $stable(uv_alarm_o) && $stable(uv_warn_o)
                 && $stable(fault_o)));

  assert_no_bad_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o & (crc_err_o | ovt_o | uv_alarm_o | fault_o)) == '0);

  for (genvar d = 0; d < N_DEV; d++) begin : g_z
    assert_blank_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_o[d] |-> (data_o[d*8 +: 8] == 8'h00));
  end
endmodule

bind chain_reader chain_reader_chk #(.N_DEV(N_DEV)) u_chain_reader_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .spi_cs_no  (spi_cs_no),
  .spi_sclk_o (spi_sclk_o),
  .done_o     (done_o),
  .data_o     (data_o),
  .valid_o    (valid_o),
  .crc_err_o  (crc_err_o),
  .ovt_o      (ovt_o),
  .uv_alarm_o (uv_alarm_o),
  .uv_warn_o  (uv_warn_o),
  .fault_o    (fault_o)
);

// File: tb/chain_reader_test.sv
`timescale 1ns/1ps
module chain_reader_test;
  localparam int N = 3;
  localparam int D = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b1, ign = 1'b0;
  logic [N-1:0] fpd = '0;
  logic fsh = 1'b0;
  logic miso = 1'b0;

  logic sclk [2];
  logic cs_n [2];
  logic busy [2];
  logic done [2];
  logic [N*8-1:0] data [2];
  logic [N-1:0] valid [2], crc [2], ovt [2], uva [2], uvw [2], flt [2];

  always #5 clk = ~clk;

  chain_reader #(.N_DEV(N), .CLK_DIV(D), .SHARED_FAULT(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .status_mode_i(mode),
    .ignore_uv_i(ign), .fault_i(fpd), .spi_sclk_o(sclk[0]), .spi_cs_no(cs_n[0]),
    .spi_miso_i(miso), .busy_o(busy[0]), .done_o(done[0]), .data_o(data[0]),
    .valid_o(valid[0]), .crc_err_o(crc[0]), .ovt_o(ovt[0]), .uv_alarm_o(uva[0]),
    .uv_warn_o(uvw[0]), .fault_o(flt[0]));

  chain_reader #(.N_DEV(N), .CLK_DIV(D), .SHARED_FAULT(1'b1)) uut_sh (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .status_mode_i(mode),
    .ignore_uv_i(ign), .fault_i(fsh), .spi_sclk_o(sclk[1]), .spi_cs_no(cs_n[1]),
    .spi_miso_i(miso), .busy_o(busy[1]), .done_o(done[1]), .data_o(data[1]),
    .valid_o(valid[1]), .crc_err_o(crc[1]), .ovt_o(ovt[1]), .uv_alarm_o(uva[1]),
    .uv_warn_o(uvw[1]), .fault_o(flt[1]));

  int vectors = 0, miscompares = 0, cyc = 0;
  string cur_tag = "R10";

  // ---------------- slave model of the chain ----------------
  logic [N*16-1:0] tx = '0;
  int tx_len = N * 16;
  int idx = 0;
  int rises = 0;
  logic [7:0] in_b [N];
  logic [7:0] st_b [N];

  always @(negedge cs_n[0]) begin
    idx  = 0;
    miso = tx[tx_len-1];
  end
  always @(negedge sclk[0]) if (!cs_n[0]) begin
    idx = idx + 1;
    if (idx < tx_len) miso = tx[tx_len-1-idx];
  end
  always @(posedge sclk[0]) rises = rises + 1;

  function automatic logic [4:0] ref_crc(input logic [7:0] d);
    logic [12:0] r;
    r = {d, 5'b0};
    for (int b = 12; b >= 5; b--)
      if (r[b]) r = r ^ (13'b110101 << (b - 5));
    return r[4:0];
  endfunction

  function automatic logic [7:0] st_good(input logic [7:0] d);
    return {ref_crc(d), 3'b101};
  endfunction

  // ---------------- expected values ----------------
  logic [N*8-1:0] e_data [2], n_data [2];
  logic [N-1:0] e_valid [2], e_crc [2], e_ovt [2], e_uva [2], e_uvw [2], e_flt [2];
  logic [N-1:0] n_valid [2], n_crc [2], n_ovt [2], n_uva [2], n_uvw [2], n_flt [2];
  logic e_done = 1'b0;

  task automatic calc(input int k, input bit m, input bit ig, input logic [N-1:0] fp);
    for (int d = 0; d < N; d++) begin
      logic c, o, a, w, f, bad;
      f = !ig && fp[d];
      c = m && (st_b[d][7:3] != ref_crc(in_b[d]));
      o = m && st_b[d][1];
      a = m && !ig && !st_b[d][2];
      w = m && !ig && !st_b[d][0];
      bad = f | c | o | a;
      n_crc[k][d] = c; n_ovt[k][d] = o; n_uva[k][d] = a; n_uvw[k][d] = w;
      n_flt[k][d] = f; n_valid[k][d] = !bad;
      n_data[k][d*8 +: 8] = bad ? 8'h00 : in_b[d];
    end
  endtask

  task automatic cmp(input string what, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s (%s, test %s): actual %h expected %h", req, what, cur_tag, act, exp);
    end
  endtask

  logic cs_prev = 1'b1;
  logic apply = 1'b0;
  always @(negedge clk) if (rst_n) begin
    e_done = apply;
    if (apply)
      for (int k = 0; k < 2; k++) begin
        e_data[k] = n_data[k]; e_valid[k] = n_valid[k]; e_crc[k] = n_crc[k];
        e_ovt[k] = n_ovt[k]; e_uva[k] = n_uva[k]; e_uvw[k] = n_uvw[k]; e_flt[k] = n_flt[k];
      end
    for (int k = 0; k < 2; k++) begin
      cmp("done", "R10", 32'(done[k]), 32'(e_done));
      cmp("data", "R2", 32'(data[k]), 32'(e_data[k]));
      cmp("valid", "R9", 32'(valid[k]), 32'(e_valid[k]));
      cmp("crc_err", "R3", 32'(crc[k]), 32'(e_crc[k]));
      cmp("ovt", "R4", 32'(ovt[k]), 32'(e_ovt[k]));
      cmp("uv_alarm", "R5", 32'(uva[k]), 32'(e_uva[k]));
      cmp("uv_warn", "R5", 32'(uvw[k]), 32'(e_uvw[k]));
      cmp("fault", "R7", 32'(flt[k]), 32'(e_flt[k]));
    end
    apply   = !cs_prev && cs_n[0];
    cs_prev = cs_n[0];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      miscompares++;
      $display("FAIL watchdog (R10): actual timeout expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // ---------------- one readout ----------------
  task automatic run(input bit m, input bit ig, input logic [N-1:0] fp, input bit fs,
                     input bit poke, input string tag);
    cur_tag = tag;
    tx = '0;
    for (int d = 0; d < N; d++)
      if (m) tx = {tx[N*16-17:0], in_b[d], st_b[d]};
      else   tx = {tx[N*16-9:0], in_b[d]};
    tx_len = m ? N * 16 : N * 8;
    calc(0, m, ig, fp);
    calc(1, m, ig, {N{fs}});
    mode = m; ign = ig; fpd = fp; fsh = fs;
    rises = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    mode = ~m; ign = ~ig;   // R12: changes after start must not matter
    if (poke) begin         // R11: start while busy
      repeat (10) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (!done[0]) @(negedge clk);
    cmp("sclk rises", "R1", 32'(rises), 32'(tx_len));
    cmp("cs idle", "R1", 32'({cs_n[0], sclk[0], busy[0]}), 32'(3'b100));
    repeat (3) @(negedge clk);
  endtask

  task automatic good_set(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    in_b[0] = a; in_b[1] = b; in_b[2] = c;
    for (int d = 0; d < N; d++) st_b[d] = st_good(in_b[d]);
  endtask

  initial begin
    for (int d = 0; d < N; d++) begin
      e_data[d % 2] = '0;
    end
    for (int k = 0; k < 2; k++) begin
      e_data[k] = '0; e_valid[k] = '0; e_crc[k] = '0; e_ovt[k] = '0;
      e_uva[k] = '0; e_uvw[k] = '0; e_flt[k] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_tag = "R10";
    cmp("reset cs/sclk/busy", "R10", 32'({cs_n[0], sclk[0], busy[0]}), 32'(3'b100));

    good_set(8'hA5, 8'h3C, 8'h01);
    run(1'b1, 1'b0, 3'b000, 1'b0, 1'b0, "R2");
    good_set(8'h5A, 8'hC3, 8'h80);
    st_b[1] = st_b[1] ^ 8'h40;
    run(1'b1, 1'b0, 3'b000, 1'b0, 1'b0, "R3");
    good_set(8'h11, 8'h22, 8'h33);
    st_b[0][1] = 1'b1;
    run(1'b1, 1'b0, 3'b000, 1'b0, 1'b0, "R4");
    good_set(8'h44, 8'h55, 8'h66);
    st_b[1][0] = 1'b0;
    st_b[2][2] = 1'b0;
    run(1'b1, 1'b0, 3'b000, 1'b0, 1'b0, "R5");
    run(1'b1, 1'b1, 3'b101, 1'b1, 1'b0, "R6");
    good_set(8'h0F, 8'hF0, 8'h99);
    run(1'b1, 1'b0, 3'b100, 1'b1, 1'b0, "R7");
    in_b[0] = 8'hFF; in_b[1] = 8'h00; in_b[2] = 8'h5A;
    st_b[0] = 8'h00; st_b[1] = 8'h02; st_b[2] = 8'h00;
    run(1'b0, 1'b0, 3'b001, 1'b0, 1'b0, "R8");
    run(1'b0, 1'b1, 3'b111, 1'b1, 1'b0, "R12");
    good_set(8'h7E, 8'h81, 8'h24);
    run(1'b1, 1'b0, 3'b010, 1'b0, 1'b1, "R11");
    good_set(8'hC0, 8'h03, 8'hE7);
    run(1'b1, 1'b0, 3'b000, 1'b0, 1'b0, "R9");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule